// File: doc/BRIEF.md
# Register Valid-Bit Scoreboard

This block is the issue interlock for the decode stage of an in-order pipeline. It holds a single ready flag for each architectural register. A flag drops when an instruction that targets that register leaves decode. It rises again when the result of that instruction is written back. Each cycle the decode stage offers one instruction. The instruction may name up to two source registers and one destination register, and each of these has its own use flag. The block raises a stall whenever any register the instruction uses is not ready.

The destination is checked in the same way as the sources. An instruction therefore waits behind an older writer of its target as well as behind older writers of its inputs. This makes the interlock conservative for true, output and anti dependences, and the whole cost is one bit per register. The decode stage treats `issue_o` as its advance signal. Forwarding and renaming sit outside this block.

Top module: `reg_scoreboard`

## Requirements
- R1: After a synchronous active-low reset every register is ready, so a decoding instruction that uses any registers is not stalled.
- R2: When an instruction issues with `dst_use_i` = 1, the ready flag of `dst_idx_i` drops from the next cycle onward.
- R3: A write-back (`wb_en_i` = 1) makes register `wb_idx_i` ready from the cycle after the write-back. During the write-back cycle itself the flag keeps its old value, because there is no same-cycle bypass.
- R4: `stall_o` is 1 when a source with its use flag set (`src_a_use_i` or `src_b_use_i`) names a register that is not ready. Each source slot is checked independently.
- R5: `stall_o` is 1 when `dst_use_i` = 1 and the destination register is not ready, which covers write-after-write.
- R6: An operand slot whose use flag is 0 never causes a stall, whatever register it names.
- R7: A ready flag drops only for an instruction that actually issues. A stalled instruction leaves its destination's flag unchanged, and so does a cycle with `dec_valid_i` = 0.
- R8: If an issue targets a register in the same cycle as a write-back to that register, the flag ends up not ready.
- R9: Register 0 is always ready. Naming it as a destination never drops its flag.
- R10: `issue_o` = `dec_valid_i` AND NOT `stall_o`.
- R11: `stall_o` is 0 whenever `dec_valid_i` = 0.
- R12: A register index at or above `NUM_REGS` counts as ready and is never tracked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| dec_valid_i | input | 1 | An instruction is present at decode |
| src_a_use_i | input | 1 | First source operand is used |
| src_a_idx_i | input | IDX_W | First source register index |
| src_b_use_i | input | 1 | Second source operand is used |
| src_b_idx_i | input | IDX_W | Second source register index |
| dst_use_i | input | 1 | Instruction writes a destination register |
| dst_idx_i | input | IDX_W | Destination register index |
| wb_en_i | input | 1 | A result is written back this cycle |
| wb_idx_i | input | IDX_W | Register index being written back |
| stall_o | output | 1 | Hold the decoding instruction |
| issue_o | output | 1 | Decoding instruction leaves decode this cycle |

## Verification
The bench builds the block with 12 registers and 4-bit indices. With these values the indices 12 to 15 lie outside the tracked range, so the untracked-index rule can be driven directly through every operand slot. The small register count keeps every tracked flag reachable in a short sequence. That sequence covers all three dependence kinds, the same-cycle priority between issue and write-back, and a chain of two outstanding writers that retire one at a time.

// File: rtl/sb_pkg.sv
// Shared definitions for the register scoreboard.
// Assumes the decode stage presents at most three operand slots per cycle.
package sb_pkg;
    localparam int NUM_OPS = 3;

    typedef enum logic [1:0] {
        SLOT_SRC_A = 2'd0,
        SLOT_SRC_B = 2'd1,
        SLOT_DST   = 2'd2
    } op_slot_e;
endpackage

// File: rtl/sb_ready_bits.sv
// Per-register ready flags.
// A flag drops on a clear request and rises on a write-back. When both hit
// the same register in one cycle, the clear wins. Register 0 is constant
// ready. Indices at or above NUM_REGS match no flag.
// Assumes the caller has already qualified clr_en_i with an actual issue.
module sb_ready_bits #(
    parameter int NUM_REGS = 32,
    parameter int IDX_W    = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr_en_i,
    input  logic [IDX_W-1:0]    clr_idx_i,
    input  logic                set_en_i,
    input  logic [IDX_W-1:0]    set_idx_i,
    output logic [NUM_REGS-1:0] ready_o
);
    for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
        localparam logic [IDX_W-1:0] K_IDX = IDX_W'(k);
        if (k == 0) begin : g_zero
            // Register 0 never becomes busy.
            assign ready_o[k] = 1'b1;
        end else begin : g_flag
            logic rdy_q;
            logic clr_hit;
            logic set_hit;

            // Decode the two request ports against this register.
            always_comb begin
                clr_hit = clr_en_i && (clr_idx_i == K_IDX);
                set_hit = set_en_i && (set_idx_i == K_IDX);
            end

            // Flag update: reset to ready, clear beats set.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    rdy_q <= 1'b1;
                end else if (clr_hit) begin
                    rdy_q <= 1'b0;
                end else if (set_hit) begin
                    rdy_q <= 1'b1;
                end
            end

            assign ready_o[k] = rdy_q;

            AST_CLEAR_BEATS_SET: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_en_i && clr_idx_i == K_IDX) |=> !ready_o[k]); // R8
            AST_WB_SETS: assert property (@(posedge clk) disable iff (!rst_n)
                (set_en_i && set_idx_i == K_IDX && !(clr_en_i && clr_idx_i == K_IDX)) |=> ready_o[k]); // R3
            AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
                (!(clr_en_i && clr_idx_i == K_IDX) && !(set_en_i && set_idx_i == K_IDX)) |=> $stable(ready_o[k])); // R7
        end
    end
endmodule

// File: rtl/sb_operand_probe.sv
// Checks one operand slot against the ready flags.
// The slot is busy when it is in use, its index is tracked and the flag is low.
// Assumes indices at or above NUM_REGS are untracked and so always ready.
module sb_operand_probe #(
    parameter int NUM_REGS = 32,
    parameter int IDX_W    = 5
) (
    input  logic                use_i,
    input  logic [IDX_W-1:0]    idx_i,
    input  logic [NUM_REGS-1:0] ready_i,
    output logic                busy_o
);
    logic tracked;

    // Decide whether this operand blocks the instruction.
    always_comb begin
        tracked = (int'(idx_i) < NUM_REGS);
        busy_o  = 1'b0;
        if (use_i && tracked) begin
            busy_o = !ready_i[idx_i];
        end
    end
endmodule

// File: rtl/reg_scoreboard.sv
// Decode-stage issue interlock built on one ready bit per register.
// All used operands, the destination included, must be ready for issue.
// An issuing writer marks its destination busy, and write-back marks it ready.
// Assumes a single decode slot and a single write-back port per cycle.
module reg_scoreboard #(
    parameter int NUM_REGS = 32,
    parameter int IDX_W    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dec_valid_i,
    input  logic             src_a_use_i,
    input  logic [IDX_W-1:0] src_a_idx_i,
    input  logic             src_b_use_i,
    input  logic [IDX_W-1:0] src_b_idx_i,
    input  logic             dst_use_i,
    input  logic [IDX_W-1:0] dst_idx_i,
    input  logic             wb_en_i,
    input  logic [IDX_W-1:0] wb_idx_i,
    output logic             stall_o,
    output logic             issue_o
);
    import sb_pkg::*;

    logic [NUM_REGS-1:0] ready_vec;
    logic [IDX_W-1:0]    slot_idx  [NUM_OPS];
    logic                slot_use  [NUM_OPS];
    logic [NUM_OPS-1:0]  slot_busy;
    logic                clr_en;

    // Gather the operand slots into arrays for the probes.
    always_comb begin
        slot_idx[SLOT_SRC_A] = src_a_idx_i;
        slot_use[SLOT_SRC_A] = src_a_use_i;
        slot_idx[SLOT_SRC_B] = src_b_idx_i;
        slot_use[SLOT_SRC_B] = src_b_use_i;
        slot_idx[SLOT_DST]   = dst_idx_i;
        slot_use[SLOT_DST]   = dst_use_i;
    end

    for (genvar s = 0; s < NUM_OPS; s++) begin : g_probe
        sb_operand_probe #(
            .NUM_REGS (NUM_REGS),
            .IDX_W    (IDX_W)
        ) i_probe (
            .use_i   (slot_use[s]),
            .idx_i   (slot_idx[s]),
            .ready_i (ready_vec),
            .busy_o  (slot_busy[s])
        );
    end

    // Stall and issue decision for the decoding instruction.
    always_comb begin
        stall_o = dec_valid_i && (|slot_busy);
        issue_o = dec_valid_i && !stall_o;
        clr_en  = issue_o && dst_use_i;
    end

    sb_ready_bits #(
        .NUM_REGS (NUM_REGS),
        .IDX_W    (IDX_W)
    ) i_ready_bits (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_en_i  (clr_en),
        .clr_idx_i (dst_idx_i),
        .set_en_i  (wb_en_i),
        .set_idx_i (wb_idx_i),
        .ready_o   (ready_vec)
    );

    AST_SRC_A_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_o && src_a_use_i && int'(src_a_idx_i) < NUM_REGS) |-> ready_vec[src_a_idx_i]); // R4
    AST_SRC_B_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_o && src_b_use_i && int'(src_b_idx_i) < NUM_REGS) |-> ready_vec[src_b_idx_i]); // R4
    AST_DST_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_o && dst_use_i && int'(dst_idx_i) < NUM_REGS) |-> ready_vec[dst_idx_i]); // R5
    AST_IDLE_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid_i |-> (!stall_o && !issue_o)); // R11
    AST_ZERO_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid_i && src_a_use_i && src_a_idx_i == '0 && !src_b_use_i && !dst_use_i) |-> issue_o); // R9
endmodule

// File: tb/test_reg_scoreboard.sv
// Scoreboard bench: the driver predicts from its own flag model and queues
// the expectation, and the monitor compares at the falling edge.
module test_reg_scoreboard;
    localparam int CLK_PERIOD = 10;
    localparam int N_REGS     = 12;
    localparam int IW         = 4;
    localparam int WATCHDOG   = 5000;

    typedef struct {
        logic  stall;
        logic  issue;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dec_valid = 1'b0;
    logic a_use = 1'b0, b_use = 1'b0, d_use = 1'b0, wb_en = 1'b0;
    logic [IW-1:0] a_idx = '0, b_idx = '0, d_idx = '0, wb_idx = '0;
    logic stall, issue;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;
    bit model_rdy [N_REGS];
    exp_t exp_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    reg_scoreboard #(.NUM_REGS(N_REGS), .IDX_W(IW)) i_reg_scoreboard (
        .clk(clk), .rst_n(rst_n), .dec_valid_i(dec_valid),
        .src_a_use_i(a_use), .src_a_idx_i(a_idx),
        .src_b_use_i(b_use), .src_b_idx_i(b_idx),
        .dst_use_i(d_use), .dst_idx_i(d_idx),
        .wb_en_i(wb_en), .wb_idx_i(wb_idx),
        .stall_o(stall), .issue_o(issue)
    );

    function automatic bit is_ready(logic [IW-1:0] r);
        if (r == 0 || int'(r) >= N_REGS) return 1'b1;
        return model_rdy[r];
    endfunction

    // Drive one decode cycle, queue the expected result and advance the model.
    task automatic step(input logic dv, input logic au, input int a,
                        input logic bu, input int b, input logic du, input int d,
                        input logic we, input int w, input string tag);
        exp_t e;
        @(posedge clk);
        #1;
        dec_valid = dv; a_use = au; a_idx = IW'(a); b_use = bu; b_idx = IW'(b);
        d_use = du; d_idx = IW'(d); wb_en = we; wb_idx = IW'(w);
        e.stall = dv && ((au && !is_ready(IW'(a))) || (bu && !is_ready(IW'(b)))
                         || (du && !is_ready(IW'(d))));
        e.issue = dv && !e.stall;
        e.tag   = tag;
        exp_q.push_back(e);
        if (we && w != 0 && w < N_REGS) model_rdy[w] = 1'b1;
        if (e.issue && du && d != 0 && d < N_REGS) model_rdy[d] = 1'b0;
    endtask

    // Monitor: compare queued expectations away from the active edge.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            total++;
            if (stall !== e.stall || issue !== e.issue) begin
                bad++;
                $display("FAIL %s: stall/issue actual=%b%b expected=%b%b",
                         e.tag, stall, issue, e.stall, e.issue);
            end
        end
    end

    initial begin
        for (int i = 0; i < WATCHDOG; i++) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N_REGS; i++) model_rdy[i] = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        step(1, 1, 1, 1, 2, 1, 3, 0, 0, "R1 all ready after reset");
        step(1, 1, 3, 0, 0, 1, 5, 0, 0, "R2 R4 src A on busy reg");
        step(1, 0, 0, 1, 3, 0, 0, 0, 0, "R4 src B on busy reg");
        step(1, 0, 0, 0, 0, 1, 3, 0, 0, "R5 WAW on busy dst");
        step(1, 0, 3, 0, 3, 0, 3, 0, 0, "R6 unused slots ignored");
        step(0, 0, 0, 0, 0, 1, 6, 0, 0, "R11 R10 idle decode");
        step(1, 1, 5, 1, 6, 1, 0, 0, 0, "R7 stalled and idle did not clear");
        step(1, 1, 0, 0, 0, 0, 0, 0, 0, "R9 reg zero stays ready");
        step(1, 1, 3, 0, 0, 0, 0, 1, 3, "R3 no bypass in wb cycle");
        step(1, 1, 3, 0, 0, 0, 0, 0, 0, "R3 ready after wb");
        step(1, 0, 0, 0, 0, 1, 4, 1, 4, "R8 issue with wb same reg");
        step(1, 1, 4, 0, 0, 0, 0, 0, 0, "R8 clear won");
        step(1, 0, 0, 0, 0, 0, 0, 1, 4, "R3 release reg 4");
        step(1, 0, 0, 1, 4, 0, 0, 0, 0, "R3 reg 4 ready");
        step(1, 1, 13, 1, 15, 1, 14, 0, 0, "R12 untracked indices");
        step(1, 0, 0, 0, 0, 1, 14, 0, 0, "R12 untracked dst not busy");
        step(1, 0, 0, 0, 0, 1, 7, 0, 0, "R2 issue writer of 7");
        step(1, 0, 0, 0, 0, 1, 8, 0, 0, "R2 issue writer of 8");
        step(1, 1, 7, 1, 8, 0, 0, 1, 7, "R4 both busy");
        step(1, 1, 7, 1, 8, 0, 0, 0, 0, "R4 second source still busy");
        step(1, 1, 7, 1, 8, 0, 0, 1, 8, "R3 wb of 8");
        step(1, 1, 7, 1, 8, 1, 11, 0, 0, "R10 chain drained");
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R11 idle");
        repeat (3) @(posedge clk);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule